// File: doc/BRIEF.md
# Inverted Page Table Translator

This block turns a virtual address into a physical address using a table with one slot per physical frame. Each slot holds a valid flag and the virtual page number that currently lives in that frame. A translation does not read a stored frame number. It searches the slots for the virtual page, and the position of the matching slot is the frame number. The page offset is passed through unchanged. If no valid slot holds the page, the block reports a page fault.

A requester starts a translation by raising `lk_req` for one cycle while `lk_ready` is high. The controller then checks one slot per cycle, starting at slot 0. It raises `xl_hit` or `xl_fault` for a single cycle when the search ends. A separate update port writes or invalidates one slot. An update is held while a search runs and is applied only once the controller is idle again.

Controller states and transitions:
- `ST_IDLE`: goes to `ST_SCAN` on an accepted request, or to `ST_WACK` on an update.
- `ST_SCAN`: goes back to `ST_IDLE` on a match or after the last slot.
- `ST_WACK`: goes back to `ST_IDLE` after one cycle.

Top module: `ipt_xlate`

## Requirements
- R1: After reset, every slot is invalid. `lk_ready` is 1 and `xl_hit`, `xl_fault`, `wr_ack` and `paddr` are all 0. Any lookup made before the first update therefore faults.
- R2: On a hit, `paddr` is `{frame, offset}`. The frame is the index of the matching slot, and the offset is the low `OFF_W` bits of `lk_vaddr`, copied unchanged.
- R3: With the default parameters, slot 4 holds page `4'b1010`. A lookup of `7'b1010_110` then gives `paddr = 6'b100_110`.
- R4: A slot whose valid flag is 0 never matches, even when its stored page equals the requested one.
- R5: When no valid slot matches, `xl_fault` pulses and `paddr` keeps its previous value.
- R6: When several valid slots hold the same page, the lowest index wins.
- R7: Let the accepting edge be edge 0. A hit at slot i is reported after edge i+1, and a fault after edge FRAMES. `lk_ready` is 0 for the whole search.
- R8: An update (`wr_req` with `wr_frame`, `wr_present`, `wr_vpn`) sets the valid flag and page of that slot. When the controller is idle, the update is applied at the next edge and `wr_ack` pulses for one cycle after it.
- R9: An update raised during a search is held. `wr_ack` stays 0 until the search has reported, and the search result reflects the table as it was before the update.
- R10: If `lk_req` and `wr_req` arrive together while idle, the lookup is accepted first and the update follows it.
- R11: `xl_hit`, `xl_fault` and `wr_ack` are single-cycle pulses, and `xl_hit` and `xl_fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Start a translation; only honoured while `lk_ready` is high |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address: page in the upper bits, offset in the lower bits |
| lk_ready | output | 1 | Controller idle and able to accept a request |
| xl_hit | output | 1 | One-cycle pulse: translation found |
| xl_fault | output | 1 | One-cycle pulse: page fault |
| paddr | output | FRAME_W+OFF_W | Last translated physical address |
| wr_req | input | 1 | Update request, held high until `wr_ack` is seen |
| wr_frame | input | FRAME_W | Slot (frame) to update |
| wr_present | input | 1 | New valid flag |
| wr_vpn | input | VPN_W | New virtual page number |
| wr_ack | output | 1 | One-cycle pulse after an update is applied |

## Verification
The assertions assume that `lk_req` is raised only in a cycle where `lk_ready` is high. They also assume that `wr_req` and its fields stay steady from the cycle they are raised until `wr_ack` is seen, and drop in that cycle. The bench drives every input on the falling edge. Its lookup task waits for `lk_ready` before pulsing `lk_req` and drops it one cycle later. Its update task holds the request and releases it in the cycle `wr_ack` is observed, so the stimulus never leaves the handshake those checks rely on.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WACK = 2'd2
    } ipt_state_e;
endpackage

// File: rtl/ipt_table.sv
// Per-frame slot storage: valid flag plus resident virtual page number.
module ipt_table #(
    parameter int VPN_W   = 4,
    parameter int FRAMES  = 8,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [FRAME_W-1:0] wsel,
    input  logic               wpres,
    input  logic [VPN_W-1:0]   wvpn,
    input  logic [FRAME_W-1:0] rsel,
    output logic               rpres,
    output logic [VPN_W-1:0]   rvpn
);
    logic             pres_q [FRAMES];
    logic [VPN_W-1:0] vpn_q  [FRAMES];

    for (genvar g = 0; g < FRAMES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q[g] <= 1'b0;
                vpn_q[g]  <= '0;
            end else if (we && (wsel == FRAME_W'(g))) begin
                pres_q[g] <= wpres;
                vpn_q[g]  <= wvpn;
            end
        end
    end

    assign rpres = pres_q[rsel];
    assign rvpn  = vpn_q[rsel];
endmodule

// File: rtl/ipt_cmp.sv
// Slot comparator: an invalid slot never matches.
module ipt_cmp #(
    parameter int VPN_W = 4
) (
    input  logic             slot_pres,
    input  logic [VPN_W-1:0] slot_vpn,
    input  logic [VPN_W-1:0] key,
    output logic             match
);
    always_comb begin
        match = slot_pres && (slot_vpn == key);
    end
endmodule

// File: rtl/ipt_ctrl.sv
// Search sequencer: walks slots from index 0, reports hit or fault,
// and applies held updates only while idle.
module ipt_ctrl
    import ipt_pkg::*;
#(
    parameter int VPN_W   = 4,
    parameter int OFF_W   = 3,
    parameter int FRAMES  = 8,
    parameter int FRAME_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_req,
    input  logic [VPN_W+OFF_W-1:0]   lk_vaddr,
    input  logic                     wr_req,
    input  logic                     match,
    output logic [FRAME_W-1:0]       rsel,
    output logic [VPN_W-1:0]         key,
    output logic                     tbl_we,
    output logic                     lk_ready,
    output logic                     xl_hit,
    output logic                     xl_fault,
    output logic [FRAME_W+OFF_W-1:0] paddr,
    output logic                     wr_ack
);
    localparam int VA_W = VPN_W + OFF_W;
    localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(FRAMES - 1);

    ipt_state_e         state_q, state_d;
    logic [FRAME_W-1:0] idx_q;
    logic [VPN_W-1:0]   key_q;
    logic [OFF_W-1:0]   off_q;
    logic               last_slot;

    assign last_slot = (idx_q == LAST_IDX);
    assign rsel      = idx_q;
    assign key       = key_q;
    assign lk_ready  = (state_q == ST_IDLE);
    assign tbl_we    = (state_q == ST_IDLE) && !lk_req && wr_req;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (lk_req)      state_d = ST_SCAN;
                else if (wr_req) state_d = ST_WACK;
            end
            ST_SCAN: begin
                if (match || last_slot) state_d = ST_IDLE;
            end
            ST_WACK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and search datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            key_q    <= '0;
            off_q    <= '0;
            xl_hit   <= 1'b0;
            xl_fault <= 1'b0;
            wr_ack   <= 1'b0;
            paddr    <= '0;
        end else begin
            xl_hit   <= 1'b0;
            xl_fault <= 1'b0;
            wr_ack   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (lk_req) begin
                        key_q <= lk_vaddr[VA_W-1:OFF_W];
                        off_q <= lk_vaddr[OFF_W-1:0];
                        idx_q <= '0;
                    end else if (wr_req) begin
                        wr_ack <= 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (match) begin
                        xl_hit <= 1'b1;
                        paddr  <= {idx_q, off_q};
                    end else if (last_slot) begin
                        xl_fault <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_WACK: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ipt_xlate.sv
module ipt_xlate #(
    parameter int VPN_W   = 4,
    parameter int OFF_W   = 3,
    parameter int FRAMES  = 8,
    localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int VA_W    = VPN_W + OFF_W,
    localparam int PA_W    = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [VA_W-1:0]    lk_vaddr,
    output logic               lk_ready,
    output logic               xl_hit,
    output logic               xl_fault,
    output logic [PA_W-1:0]    paddr,
    input  logic               wr_req,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_present,
    input  logic [VPN_W-1:0]   wr_vpn,
    output logic               wr_ack
);
    logic [FRAME_W-1:0] rsel;
    logic               rpres;
    logic [VPN_W-1:0]   rvpn;
    logic [VPN_W-1:0]   key;
    logic               match;
    logic               tbl_we;

    ipt_table #(.VPN_W(VPN_W), .FRAMES(FRAMES), .FRAME_W(FRAME_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .wsel  (wr_frame),
        .wpres (wr_present),
        .wvpn  (wr_vpn),
        .rsel  (rsel),
        .rpres (rpres),
        .rvpn  (rvpn)
    );

    ipt_cmp #(.VPN_W(VPN_W)) u_cmp (
        .slot_pres (rpres),
        .slot_vpn  (rvpn),
        .key       (key),
        .match     (match)
    );

    ipt_ctrl #(.VPN_W(VPN_W), .OFF_W(OFF_W), .FRAMES(FRAMES), .FRAME_W(FRAME_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_req   (lk_req),
        .lk_vaddr (lk_vaddr),
        .wr_req   (wr_req),
        .match    (match),
        .rsel     (rsel),
        .key      (key),
        .tbl_we   (tbl_we),
        .lk_ready (lk_ready),
        .xl_hit   (xl_hit),
        .xl_fault (xl_fault),
        .paddr    (paddr),
        .wr_ack   (wr_ack)
    );
endmodule

// File: rtl/ipt_xlate_chk.sv
module ipt_xlate_chk #(
    parameter int OFF_W   = 3,
    parameter int FRAMES  = 8,
    parameter int PA_W    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [OFF_W-1:0] lk_off,
    input logic             lk_ready,
    input logic             wr_req,
    input logic             wr_ack,
    input logic             xl_hit,
    input logic             xl_fault,
    input logic [PA_W-1:0]  paddr
);
    logic [OFF_W-1:0] cap_off;
    int               cnt;

    // search-length counter and captured offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_off <= '0;
            cnt     <= 0;
        end else if (lk_req && lk_ready) begin
            cap_off <= lk_off;
            cnt     <= 0;
        end else if (!lk_ready) begin
            cnt <= cnt + 1;
        end
    end

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_hit && xl_fault));
    p_hit_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |=> !xl_hit);
    p_fault_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |=> !xl_fault);
    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);
    p_offset_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (paddr[OFF_W-1:0] == cap_off));
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_ready) |=> !lk_ready);
    p_fault_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> (cnt == FRAMES));
    p_hit_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (cnt >= 1 && cnt <= FRAMES));
    p_hold_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> $stable(paddr));
    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> $past(lk_ready && !lk_req && wr_req));
endmodule

bind ipt_xlate ipt_xlate_chk #(.OFF_W(OFF_W), .FRAMES(FRAMES), .PA_W(PA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_off   (lk_vaddr[OFF_W-1:0]),
    .lk_ready (lk_ready),
    .wr_req   (wr_req),
    .wr_ack   (wr_ack),
    .xl_hit   (xl_hit),
    .xl_fault (xl_fault),
    .paddr    (paddr)
);

// File: tb/ipt_xlate_test.sv
`timescale 1ns/1ps
module ipt_xlate_test;
    localparam int VPN_W = 4, OFF_W = 3, FRAMES = 8, FW = 3;
    localparam int VA_W = VPN_W + OFF_W, PA_W = FW + OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic lk_ready, xl_hit, xl_fault, wr_ack;
    logic [PA_W-1:0] paddr;
    logic wr_req = 1'b0;
    logic [FW-1:0] wr_frame = '0;
    logic wr_present = 1'b0;
    logic [VPN_W-1:0] wr_vpn = '0;

    int total = 0, bad = 0, cyc = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    ipt_xlate uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_ready(lk_ready), .xl_hit(xl_hit), .xl_fault(xl_fault), .paddr(paddr),
        .wr_req(wr_req), .wr_frame(wr_frame), .wr_present(wr_present),
        .wr_vpn(wr_vpn), .wr_ack(wr_ack)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit             m_pres [FRAMES];
    bit [VPN_W-1:0] m_vpn  [FRAMES];
    bit m_busy, m_wack, m_hit, m_fault, m_found;
    int m_wait, m_idx;
    bit [OFF_W-1:0] m_off;
    bit [PA_W-1:0]  m_pa;

    function automatic int find_slot(input bit [VPN_W-1:0] v);
        for (int i = 0; i < FRAMES; i++)
            if (m_pres[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < FRAMES; i++) begin m_pres[i] <= 0; m_vpn[i] <= 0; end
            m_busy <= 0; m_wack <= 0; m_hit <= 0; m_fault <= 0; m_pa <= 0;
            m_wait <= 0;
        end else begin
            m_hit <= 0; m_fault <= 0; m_wack <= 0;
            if (m_busy) begin
                if (m_wait == 1) begin
                    m_busy <= 0;
                    if (m_found) begin m_hit <= 1; m_pa <= {FW'(m_idx), m_off}; end
                    else m_fault <= 1;
                end
                m_wait <= m_wait - 1;
            end else if (!m_wack) begin
                if (lk_req) begin
                    automatic int s = find_slot(lk_vaddr[VA_W-1:OFF_W]);
                    m_busy  <= 1;
                    m_found <= (s >= 0);
                    m_idx   <= s;
                    m_off   <= lk_vaddr[OFF_W-1:0];
                    m_wait  <= (s >= 0) ? s + 1 : FRAMES;
                end else if (wr_req) begin
                    m_pres[wr_frame] <= wr_present;
                    m_vpn[wr_frame]  <= wr_vpn;
                    m_wack <= 1;
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check(lk_ready == (!m_busy && !m_wack), "R7 lk_ready", lk_ready, !m_busy && !m_wack);
            check(xl_hit == m_hit, "R11 xl_hit", xl_hit, m_hit);
            check(xl_fault == m_fault, "R5 xl_fault", xl_fault, m_fault);
            check(wr_ack == m_wack, "R8 wr_ack", wr_ack, m_wack);
            check(paddr == m_pa, "R2 paddr", paddr, m_pa);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_write(input int fr, input bit pres, input int vpn);
        @(negedge clk);
        wr_req = 1; wr_frame = FW'(fr); wr_present = pres; wr_vpn = VPN_W'(vpn);
        do @(negedge clk); while (!wr_ack);
        wr_req = 0;
    endtask

    task automatic do_lookup(input int va, output bit h, output bit f,
                             output int pa, output int lat);
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        lk_req = 1; lk_vaddr = VA_W'(va);
        @(negedge clk);
        lk_req = 0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!xl_hit && !xl_fault && lat < 50);
        h = xl_hit; f = xl_fault; pa = paddr;
    endtask

    initial begin
        bit h, f, ack_seen;
        int pa, lat, pa_prev;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(lk_ready == 1, "R1 ready", lk_ready, 1);
        check(xl_hit == 0 && xl_fault == 0, "R1 pulses", {xl_hit, xl_fault}, 0);
        check(wr_ack == 0, "R1 ack", wr_ack, 0);
        check(paddr == 0, "R1 paddr", paddr, 0);
        cmp_on = 1;
        do_lookup(7'b1010_110, h, f, pa, lat);
        check(f && !h, "R1 empty table faults", f, 1);

        do_write(4, 1, 4'b1010);
        do_write(1, 1, 4'b0011);
        do_write(6, 1, 4'b0111);

        do_lookup(7'b1010_110, h, f, pa, lat);
        check(h, "R3 hit", h, 1);
        check(pa == 6'b100_110, "R3 paddr", pa, 6'b100_110);
        check(lat == 5, "R7 latency slot4", lat, 5);

        do_lookup(7'b0011_001, h, f, pa, lat);
        check(h && pa == 6'b001_001, "R2 paddr slot1", pa, 6'b001_001);
        check(lat == 2, "R7 latency slot1", lat, 2);

        pa_prev = pa;
        do_lookup(7'b1111_000, h, f, pa, lat);
        check(f && !h, "R5 fault", f, 1);
        check(pa == pa_prev, "R5 paddr held", pa, pa_prev);
        check(lat == FRAMES, "R7 fault latency", lat, FRAMES);

        do_write(2, 1, 4'b0111);
        do_lookup(7'b0111_101, h, f, pa, lat);
        check(h && pa == 6'b010_101, "R6 lowest index", pa, 6'b010_101);

        do_write(0, 0, 4'b1100);
        do_lookup(7'b1100_011, h, f, pa, lat);
        check(f, "R4 invalid slot ignored", f, 1);

        do_write(7, 1, 4'b1110);
        do_lookup(7'b1110_111, h, f, pa, lat);
        check(h && pa == 6'b111_111, "R7 last slot paddr", pa, 6'b111_111);
        check(lat == FRAMES, "R7 last slot latency", lat, FRAMES);

        // R9: update raised during a search is held off
        @(negedge clk);
        lk_req = 1; lk_vaddr = 7'b0111_010;
        @(negedge clk);
        lk_req = 0;
        wr_req = 1; wr_frame = 3'd2; wr_present = 0; wr_vpn = 4'b0000;
        ack_seen = 0; lat = 0;
        do begin
            @(negedge clk); lat++;
            if (wr_ack) ack_seen = 1;
        end while (!xl_hit && !xl_fault && lat < 50);
        check(xl_hit && paddr == 6'b010_010, "R9 pre-update result", paddr, 6'b010_010);
        check(!ack_seen, "R9 ack held", ack_seen, 0);
        while (!wr_ack) @(negedge clk);
        wr_req = 0;
        do_lookup(7'b0111_010, h, f, pa, lat);
        check(h && pa == 6'b110_010, "R8 cleared slot skipped", pa, 6'b110_010);

        // R10: simultaneous lookup and update in idle
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        lk_req = 1; lk_vaddr = 7'b0101_100;
        wr_req = 1; wr_frame = 3'd3; wr_present = 1; wr_vpn = 4'b0101;
        @(negedge clk);
        lk_req = 0;
        check(!lk_ready && !wr_ack, "R10 lookup first", {lk_ready, wr_ack}, 0);
        lat = 0;
        do begin @(negedge clk); lat++; end while (!xl_hit && !xl_fault && lat < 50);
        check(xl_fault, "R10 lookup saw old table", xl_fault, 1);
        while (!wr_ack) @(negedge clk);
        wr_req = 0;
        do_lookup(7'b0101_100, h, f, pa, lat);
        check(h && pa == 6'b011_100, "R10 update applied after", pa, 6'b011_100);
        check(lat == 4, "R7 latency slot3", lat, 4);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule